// File: doc/BRIEF.md
# Gated Frequency Counter Sequencer

This block measures how often an asynchronous input signal rises during a gate window set by a once-per-second timebase strobe. The result is a six-digit decimal reading in hertz. The input is first brought into the system clock domain and turned into single-cycle rising-edge events. A six-decade BCD counter adds up those events while the gate is open. When the gate closes, a small state machine runs a fixed three-step cycle. The gate closes, then a one-cycle latch copies the counter and its overflow flag into a display register, then a one-cycle clear empties the counter. After that the gate opens again at once. The display holds each result for the whole of the next gate.

The state machine has six states. `ST_IDLE` waits after reset. `ST_ARM` waits for an input edge so that the gate can open. `ST_COUNT` counts with the gate open. `ST_HOLD` keeps counting after the tick and waits for an input edge so that the gate can close. `ST_LATCH` copies the result. `ST_CLEAR` empties the counter.

The transitions depend on the build-time parameter `SYNC_GATE`:
- With `SYNC_GATE=0`: `ST_IDLE` goes to `ST_COUNT` on a tick. `ST_COUNT` goes to `ST_LATCH` on a tick.
- With `SYNC_GATE=1`: `ST_IDLE` goes to `ST_ARM` on a tick. `ST_ARM` goes to `ST_COUNT` on an input edge. `ST_COUNT` goes to `ST_HOLD` on a tick. `ST_HOLD` goes to `ST_LATCH` on an input edge.
- In both builds, `ST_LATCH` always goes to `ST_CLEAR`, and `ST_CLEAR` always goes to `ST_COUNT`.

With `SYNC_GATE=1` the gate opens and closes only on input edges, so a steady input gives a steady last digit.

An input edge that is detected during the latch or clear cycle is not lost. It is carried into the next gate. Ticks that arrive in `ST_ARM`, `ST_HOLD`, `ST_LATCH` or `ST_CLEAR` are ignored.

Top module: `freq_gate_counter`

## Requirements
- R1: After a cycle with `rst` high, the display digits and `ovf_o` are zero, `result_valid`, `gate_open`, `latch_stb` and `clear_stb` are low, and the block waits for the first tick.
- R2: Digit k of `digits_o` sits at bits [4k+3:4k], with digit 0 the least significant. Each digit holds a value from 0 to 9 and carries into digit k+1 when it steps from 9 to 0.
- R3: The tick that ends the gate is seen at a clock edge. `latch_stb` is high for exactly the next cycle, and `clear_stb` is high for exactly the cycle after that. A clear never comes without a latch in the cycle before it.
- R4: With `SYNC_GATE=0`, the first tick opens the gate in the next cycle. Each reading equals the number of input rising edges between two clears, when no edge lies within a few cycles of a tick.
- R5: An input edge that falls near a tick is counted in exactly one of the two neighbouring readings, so no edge is lost.
- R6: `result_valid` is high for one cycle, in the same cycle that the new display value first appears. The display does not change at any other time.
- R7: If the counter steps past all nines during a gate, it wraps to zero and a sticky overflow flag is set. `ovf_o` shows that flag together with the digits, and the clear resets it.
- R8: With `SYNC_GATE=1`, the gate opens on the first input rising edge after the first tick. Each later gate closes on the first input rising edge after a tick. A steady input whose period divides the tick period gives the same reading every gate, equal to the tick period divided by the input period.
- R9: Input edges seen before the gate first opens are not counted.
- R10: `gate_open` is high in every cycle in which detected edges are counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle timebase strobe, once per gate period |
| sig_in | input | 1 | Asynchronous signal to be measured |
| digits_o | output | 4*DIGITS | Held BCD reading |
| ovf_o | output | 1 | Held overflow flag for the reading |
| result_valid | output | 1 | One-cycle strobe when the display updates |
| gate_open | output | 1 | High while edges are being counted |
| latch_stb | output | 1 | High in the latch cycle |
| clear_stb | output | 1 | High in the clear cycle |

## Verification
Some behaviour is checked by assertions on every cycle:
- the latch always comes before the clear, and each lasts one cycle;
- the display and the counter stay frozen when nothing may change them;
- every digit stays in its decimal range;
- a wrap leaves all digits at zero;
- with `SYNC_GATE=1`, the gate opens and closes only on detected edges.

Other behaviour can only be shown by the bench's scenarios:
- exact readings against counted bursts;
- carrying of edges that fall right at a tick into one of the two readings;
- overflow in a short two-digit build;
- stable readings with `SYNC_GATE=1` for steady inputs.

// File: rtl/freqc_pkg.sv
package freqc_pkg;

    localparam int BCD_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_COUNT,
        ST_HOLD,
        ST_LATCH,
        ST_CLEAR
    } gate_state_t;

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[LAST-1:0], din};
        end
    end

    assign rise = sh[LAST-1] & ~sh[LAST];

endmodule

// File: rtl/bcd_counter.sv
module bcd_counter
    import freqc_pkg::*;
#(
    parameter int DIGITS = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    clr_val,
    input  logic                    inc,
    output logic [DIGITS*BCD_W-1:0] count_o,
    output logic                    wrap
);
    logic [DIGITS:0]   carry;
    logic [DIGITS-1:0] nine;

    assign carry[0] = inc;

    for (genvar i = 0; i < DIGITS; i++) begin : g_dec
        logic [BCD_W-1:0] q;

        assign nine[i]       = (q == 4'd9);
        assign carry[i+1]    = carry[i] & nine[i];
        assign count_o[i*BCD_W +: BCD_W] = q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (clr) begin
                q <= (i == 0) ? {3'b000, clr_val} : 4'd0;
            end else if (carry[i]) begin
                q <= nine[i] ? 4'd0 : q + 4'd1;
            end
        end

        p_digit_range_r2: assert property (@(posedge clk) disable iff (rst)
            q <= 4'd9)
            else $error("digit %0d out of decimal range", i);
    end

    assign wrap = carry[DIGITS];

    // R7: a wrap leaves every digit at zero
    p_wrap_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (wrap && !clr) |=> (count_o == '0))
        else $error("wrap did not zero the counter");

endmodule

// File: rtl/gate_seq.sv
module gate_seq
    import freqc_pkg::*;
#(
    parameter bit SYNC_GATE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic edge_hit,
    output logic count_en,
    output logic latch_p,
    output logic clear_p,
    output logic clear_val
);
    gate_state_t state, state_nx;
    logic        pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pend  <= 1'b0;
        end else begin
            state <= state_nx;
            pend  <= (state == ST_LATCH) && edge_hit;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (tick)     state_nx = SYNC_GATE ? ST_ARM : ST_COUNT;
            ST_ARM:   if (edge_hit) state_nx = ST_COUNT;
            ST_COUNT: if (tick)     state_nx = SYNC_GATE ? ST_HOLD : ST_LATCH;
            ST_HOLD:  if (edge_hit) state_nx = ST_LATCH;
            ST_LATCH:               state_nx = ST_CLEAR;
            ST_CLEAR:               state_nx = ST_COUNT;
            default:                state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        count_en  = 1'b0;
        latch_p   = 1'b0;
        clear_p   = 1'b0;
        clear_val = 1'b0;
        unique case (state)
            ST_COUNT, ST_HOLD: count_en = 1'b1;
            ST_LATCH:          latch_p  = 1'b1;
            ST_CLEAR: begin
                clear_p   = 1'b1;
                clear_val = pend | edge_hit;
            end
            default: ;
        endcase
    end

    p_clear_follows_latch_r3: assert property (@(posedge clk) disable iff (rst)
        latch_p |=> clear_p)
        else $error("clear did not follow latch");

    p_clear_needs_latch_r3: assert property (@(posedge clk) disable iff (rst)
        clear_p |-> $past(latch_p))
        else $error("clear without a preceding latch");

    p_single_latch_r3: assert property (@(posedge clk) disable iff (rst)
        latch_p |=> !latch_p)
        else $error("latch longer than one cycle");

    if (SYNC_GATE) begin : g_sync_chk
        p_open_on_edge_r8: assert property (@(posedge clk) disable iff (rst)
            (count_en && !$past(count_en) && !$past(clear_p)) |-> $past(edge_hit))
            else $error("gate opened without an input edge");

        p_close_on_edge_r8: assert property (@(posedge clk) disable iff (rst)
            latch_p |-> $past(edge_hit))
            else $error("gate closed without an input edge");
    end

endmodule

// File: rtl/freq_gate_counter.sv
module freq_gate_counter
    import freqc_pkg::*;
#(
    parameter int DIGITS      = 6,
    parameter int SYNC_STAGES = 2,
    parameter bit SYNC_GATE   = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sec_tick,
    input  logic                    sig_in,
    output logic [DIGITS*BCD_W-1:0] digits_o,
    output logic                    ovf_o,
    output logic                    result_valid,
    output logic                    gate_open,
    output logic                    latch_stb,
    output logic                    clear_stb
);
    localparam int DW = DIGITS * BCD_W;

    logic          rise;
    logic          count_en, latch_p, clear_p, clear_val;
    logic          inc, wrap, ovf_run;
    logic [DW-1:0] cnt;
    logic [DW-1:0] disp_q;
    logic          disp_ovf_q, valid_q;

    edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (sig_in),
        .rise (rise)
    );

    gate_seq #(.SYNC_GATE(SYNC_GATE)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (sec_tick),
        .edge_hit  (rise),
        .count_en  (count_en),
        .latch_p   (latch_p),
        .clear_p   (clear_p),
        .clear_val (clear_val)
    );

    assign inc = count_en & rise;

    bcd_counter #(.DIGITS(DIGITS)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (clear_p),
        .clr_val (clear_val),
        .inc     (inc),
        .count_o (cnt),
        .wrap    (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_run <= 1'b0;
        end else if (clear_p) begin
            ovf_run <= 1'b0;
        end else if (inc && wrap) begin
            ovf_run <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            disp_q     <= '0;
            disp_ovf_q <= 1'b0;
            valid_q    <= 1'b0;
        end else begin
            valid_q <= latch_p;
            if (latch_p) begin
                disp_q     <= cnt;
                disp_ovf_q <= ovf_run;
            end
        end
    end

    assign digits_o     = disp_q;
    assign ovf_o        = disp_ovf_q;
    assign result_valid = valid_q;
    assign gate_open    = count_en;
    assign latch_stb    = latch_p;
    assign clear_stb    = clear_p;

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid)
        else $error("result_valid longer than one cycle");

    p_disp_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !latch_p |=> ($stable(digits_o) && $stable(ovf_o)))
        else $error("display changed outside a latch");

    p_ovf_cleared_r7: assert property (@(posedge clk) disable iff (rst)
        clear_p |=> !ovf_run)
        else $error("overflow flag survived the clear");

    p_frozen_closed_r9: assert property (@(posedge clk) disable iff (rst)
        (!count_en && !clear_p) |=> $stable(cnt))
        else $error("counter moved with the gate closed");

endmodule

// File: tb/sim_freq_gate_counter.sv
module sim_freq_gate_counter;
    localparam int CLK_PERIOD = 10;
    localparam int G          = 1000;
    localparam int NG         = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_a = 1'b0, sig_a = 1'b0, tick_b = 1'b0, sig_b = 1'b0;

    logic [23:0] d0, d1;
    logic [7:0]  d2;
    logic o0, v0, g0, l0, c0;
    logic o1, v1, g1, l1, c1;
    logic o2, v2, g2, l2, c2;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    freq_gate_counter #(.DIGITS(6), .SYNC_GATE(1'b0)) u0 (
        .clk(clk), .rst(rst), .sec_tick(tick_a), .sig_in(sig_a),
        .digits_o(d0), .ovf_o(o0), .result_valid(v0), .gate_open(g0),
        .latch_stb(l0), .clear_stb(c0));

    freq_gate_counter #(.DIGITS(6), .SYNC_GATE(1'b1)) u1 (
        .clk(clk), .rst(rst), .sec_tick(tick_b), .sig_in(sig_b),
        .digits_o(d1), .ovf_o(o1), .result_valid(v1), .gate_open(g1),
        .latch_stb(l1), .clear_stb(c1));

    freq_gate_counter #(.DIGITS(2), .SYNC_GATE(1'b0)) u2 (
        .clk(clk), .rst(rst), .sec_tick(tick_a), .sig_in(sig_a),
        .digits_o(d2), .ovf_o(o2), .result_valid(v2), .gate_open(g2),
        .latch_stb(l2), .clear_stb(c2));

    function automatic logic [23:0] to_bcd(int v);
        logic [23:0] r;
        int t;
        t = v;
        for (int i = 0; i < 6; i++) begin
            r[i*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic int bcd2int(logic [23:0] v);
        int s;
        int p;
        s = 0;
        p = 1;
        for (int i = 0; i < 6; i++) begin
            s = s + int'(v[i*4 +: 4]) * p;
            p = p * 10;
        end
        return s;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    int n_a[NG];
    int h_a[NG];
    int late_a[NG];

    task automatic run_sync(int P, bit detail);
        int nread;
        nread = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 5*G + 200; c++) begin
            @(negedge clk);
            if (v1) begin
                check(d1 == to_bcd(G/P), "R8", "synced reading", int'(d1), int'(to_bcd(G/P)));
                nread++;
            end
            if (detail && c == 51)
                check(g1 == 1'b0, "R8", "gate waits for edge after tick", int'(g1), 0);
            if (detail && c == 60)
                check(g1 == 1'b1, "R8", "gate opened on edge", int'(g1), 1);
            if (detail && c == 1051)
                check(l1 == 1'b0, "R8", "no latch before closing edge", int'(l1), 0);
            sig_b  = ((c + 3) % P) < (P / 2);
            tick_b = (c % G) == 50;
        end
        check(nread >= 4, "R8", "synced readings seen", nread, 4);
        sig_b  = 1'b0;
        tick_b = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int cin;
        int exp_base;
        int r;
        int use_r;
        int nn, hh, ll;
        bit ok;
        logic [23:0] disp_prev;
        int plist[8];

        void'($urandom(32'd4242));
        plist = '{2, 4, 5, 8, 10, 20, 25, 40};

        for (int j = 0; j < NG; j++) begin
            h_a[j]    = $urandom_range(1, 3);
            n_a[j]    = $urandom_range(0, (G - 30) / (2 * h_a[j]));
            late_a[j] = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 4) : 0;
        end
        n_a[0] = 5;   h_a[0] = 2; late_a[0] = 0;
        n_a[1] = 0;   h_a[1] = 1; late_a[1] = 0;
        n_a[2] = 99;  h_a[2] = 1; late_a[2] = 0;
        n_a[3] = 100; h_a[3] = 1; late_a[3] = 0;
        n_a[4] = 450; h_a[4] = 1; late_a[4] = 1;
        n_a[5] = 3;   h_a[5] = 2; late_a[5] = 2;
        n_a[6] = 17;  h_a[6] = 3; late_a[6] = 3;
        n_a[7] = 240; h_a[7] = 2; late_a[7] = 4;
        n_a[8] = 8;   h_a[8] = 1; late_a[8] = 0;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(d0 == '0, "R1", "digits after reset", int'(d0), 0);
        check(o0 == 1'b0 && v0 == 1'b0, "R1", "ovf/valid after reset", int'({o0, v0}), 0);
        check(g0 == 1'b0 && l0 == 1'b0 && c0 == 1'b0, "R1", "strobes after reset",
              int'({g0, l0, c0}), 0);

        // R9: edges before the first tick are ignored
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            sig_a = (c >= 5) && (c < 33) && (((c - 5) / 2) % 2 == 0);
        end
        sig_a = 1'b0;
        check(g0 == 1'b0, "R9", "gate still closed before tick", int'(g0), 0);

        cin = 0;
        disp_prev = '0;
        for (int j = 0; j <= NG; j++) begin
            nn = (j < NG) ? n_a[j] : 0;
            hh = (j < NG) ? h_a[j] : 1;
            ll = (j < NG) ? late_a[j] : 0;
            for (int c = 0; c < G; c++) begin
                @(negedge clk);
                if (c == 1) begin
                    if (j == 0) begin
                        check(g0 == 1'b1, "R4", "gate opens after first tick", int'(g0), 1);
                    end else begin
                        check(l0 == 1'b1 && c0 == 1'b0, "R3", "latch cycle", int'({l0, c0}), 2);
                        check(d0 == disp_prev, "R6", "display held during latch",
                              int'(d0), int'(disp_prev));
                    end
                end
                if (c == 2 && j > 0) begin
                    check(c0 == 1'b1 && l0 == 1'b0, "R3", "clear cycle", int'({l0, c0}), 1);
                    check(v0 == 1'b1, "R6", "result_valid with new display", int'(v0), 1);
                    exp_base = n_a[j-1] + cin;
                    r = bcd2int(d0);
                    if (late_a[j-1] != 0) begin
                        ok = (r == exp_base) || (r == exp_base + 1);
                        check(ok, "R5", "boundary edge counted once", r, exp_base);
                        use_r = ok ? r : exp_base;
                        cin = (use_r == exp_base) ? 1 : 0;
                    end else begin
                        check(d0 == to_bcd(exp_base), "R2/R4", "gated reading",
                              int'(d0), int'(to_bcd(exp_base)));
                        use_r = exp_base;
                        cin = 0;
                    end
                    check(d2 == to_bcd(use_r % 100)[7:0], "R7", "two-digit wrapped reading",
                          int'(d2), int'(to_bcd(use_r % 100)[7:0]));
                    check(o2 == (use_r >= 100), "R7", "two-digit overflow flag",
                          int'(o2), int'(use_r >= 100));
                    check(o0 == 1'b0, "R7", "six-digit overflow flag", int'(o0), 0);
                    disp_prev = to_bcd(use_r);
                end
                if (c == 3) begin
                    check(v0 == 1'b0, "R6", "result_valid one cycle", int'(v0), 0);
                    check(g0 == 1'b1, "R10", "gate open after clear", int'(g0), 1);
                end
                tick_a = (c == 0) && (j < NG + 1);
                if (c >= 10 && c < 10 + 2 * hh * nn)
                    sig_a = (((c - 10) / hh) % 2) == 0;
                else if (c >= 4)
                    sig_a = (ll != 0) && (c >= G - ll);
            end
        end
        tick_a = 1'b0;
        sig_a  = 1'b0;

        run_sync(8, 1'b1);
        run_sync(plist[$urandom_range(0, 7)], 1'b0);
        run_sync(plist[$urandom_range(0, 7)], 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule